// File: doc/BRIEF.md
# Cache Way Replacement Selector

This block decides which way of a cache set gets evicted when an associative cache misses. The cache controller tells it about each access through an update port: a set index, a way, and whether the access was a hit or a fill. When the controller needs a victim, it presents a set index and that set's per-way valid bits on the query port. The selected way appears combinationally on the same cycle.

A static two-bit input chooses the replacement discipline. Four are supported: oldest-fill-first, least-recently-used, rotating pointer, and pseudo-random. Every set keeps a rank per way, which orders its ways from oldest to newest, and a rotating pointer. A random source is shared by all sets. An invalid way always beats the policy. A synchronous flush and the asynchronous reset put every set back into the same known order.

Top module: `repl_victim_sel`

## Requirements
- R1: The returned way is always below NUM_WAYS. With NUM_WAYS = 1 the returned way is always 0.
- R2: If any bit of `vq_valid` is 0, the returned way is the lowest-numbered way whose valid bit is 0, whatever the policy.
- R3: With `pol_sel` = 2'b00 (oldest-fill-first) and all ways valid, the victim is the way filled longest ago. Hit notifications (`upd_fill` = 0) do not change the victim.
- R4: With `pol_sel` = 2'b01 (least-recently-used) and all ways valid, the victim is the way touched longest ago. Both hits and fills count as touches.
- R5: With `pol_sel` = 2'b10 (rotating) and all ways valid, the victim is the set's pointer. The pointer advances by one on every fill to that set, whatever the filled way, and wraps from NUM_WAYS-1 to 0.
- R6: With `pol_sel` = 2'b11 (random) and all ways valid, the victim is L mod NUM_WAYS. L is a 16-bit register that reset loads with 16'hACE1. On every clock after reset, L shifts left and takes as its new bit 0 the XOR of its bits 15, 13, 12 and 10.
- R7: After reset or a flush, each set's ranks order way 0 as oldest up to way NUM_WAYS-1 as newest, and its pointer is 0. When a flush and an update arrive in the same cycle, the flush wins.
- R8: An update to one set leaves the victim of every other set unchanged.
- R9: An update is sampled on the clock edge, and the query result reflects it from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous return of all sets to the initial order |
| pol_sel | input | 2 | Policy: 00 oldest-fill, 01 LRU, 10 rotating, 11 random |
| upd_vld | input | 1 | Access notification valid |
| upd_set | input | SET_W | Set of the notified access |
| upd_way | input | WAY_W | Way of the notified access |
| upd_fill | input | 1 | 1 = fill (allocation), 0 = hit |
| vq_set | input | SET_W | Set being queried for a victim |
| vq_valid | input | NUM_WAYS | Valid bit per way of the queried set |
| vq_way | output | WAY_W | Selected victim way |

## Verification
Each policy runs a long stream of random hits and fills across all sets, interleaved with queries. Most queries use full valid masks, so the policy bookkeeping is exposed; the rest use sparse masks, which exercise the invalid-way shortcut. Random streams are mixed with directed sequences:
- hits that must not disturb oldest-fill order but must reorder LRU;
- enough fills to wrap the rotating pointer;
- a flush that collides with an update.

Because updates are spread over several sets, any leak of one set's state into another shows up. A single-way instance, run beside the default, shows that degenerate associativity always returns way 0.

// File: rtl/repl_victim_sel.sv
module repl_victim_sel #(
  parameter int NUM_SETS = 8,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [1:0]          pol_sel,
  input  logic                upd_vld,
  input  logic [SET_W-1:0]    upd_set,
  input  logic [WAY_W-1:0]    upd_way,
  input  logic                upd_fill,
  input  logic [SET_W-1:0]    vq_set,
  input  logic [NUM_WAYS-1:0] vq_valid,
  output logic [WAY_W-1:0]    vq_way
);

  localparam logic [WAY_W-1:0] LAST = WAY_W'(NUM_WAYS - 1);

  logic [WAY_W-1:0] rank [NUM_SETS][NUM_WAYS];
  logic [WAY_W-1:0] ptr  [NUM_SETS];
  logic [15:0]      lfsr;

  logic promote, advance;
  assign promote = upd_vld && (upd_fill || pol_sel == 2'b01);
  assign advance = upd_vld && upd_fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= 16'hACE1;
    else        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        ptr[s] <= '0;
        for (int w = 0; w < NUM_WAYS; w++) rank[s][w] <= WAY_W'(w);
      end
    end else if (flush) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        ptr[s] <= '0;
        for (int w = 0; w < NUM_WAYS; w++) rank[s][w] <= WAY_W'(w);
      end
    end else begin
      if (advance)
        ptr[upd_set] <= (ptr[upd_set] == LAST) ? '0 : ptr[upd_set] + 1'b1;
      if (promote) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          if (WAY_W'(w) == upd_way)
            rank[upd_set][w] <= LAST;
          else if (rank[upd_set][w] > rank[upd_set][upd_way])
            rank[upd_set][w] <= rank[upd_set][w] - 1'b1;
        end
      end
    end
  end

  logic [WAY_W-1:0] first_free, oldest, policy_pick;
  logic             any_free;

  assign any_free = ~&vq_valid;

  always_comb begin
    first_free = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--)
      if (!vq_valid[w]) first_free = WAY_W'(w);
  end

  always_comb begin
    oldest = '0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (rank[vq_set][w] == '0) oldest = WAY_W'(w);
  end

  always_comb begin
    case (pol_sel)
      2'b10:   policy_pick = ptr[vq_set];
      2'b11:   policy_pick = WAY_W'(lfsr % 16'(NUM_WAYS));
      default: policy_pick = oldest;
    endcase
  end

  generate
    if (NUM_WAYS == 1) begin : g_direct
      assign vq_way = '0;
    end else begin : g_assoc
      assign vq_way = any_free ? first_free : policy_pick;
    end
  endgenerate

endmodule

// File: rtl/repl_victim_chk.sv
module repl_victim_chk #(
  parameter int NUM_WAYS = 4,
  parameter int SET_W = 3,
  parameter int WAY_W = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                flush,
  input logic [1:0]          pol_sel,
  input logic                upd_vld,
  input logic [SET_W-1:0]    upd_set,
  input logic [WAY_W-1:0]    upd_way,
  input logic                upd_fill,
  input logic [SET_W-1:0]    vq_set,
  input logic [NUM_WAYS-1:0] vq_valid,
  input logic [WAY_W-1:0]    vq_way
);

  logic [WAY_W-1:0] rr_next;
  logic             full;
  assign full    = &vq_valid;
  assign rr_next = (vq_way == WAY_W'(NUM_WAYS - 1)) ? '0 : vq_way + 1'b1;

  AST_WAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(vq_way) < NUM_WAYS); // R1

  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> !vq_valid[vq_way]); // R2

  AST_FIFO_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_sel == 2'b00 && upd_vld && !upd_fill && !flush && full)
    |=> (vq_set != $past(vq_set) || !full || $past(pol_sel) != pol_sel || vq_way == $past(vq_way))); // R3

  AST_LRU_NOT_RECENT: assert property (@(posedge clk) disable iff (!rst_n)
    (NUM_WAYS > 1 && pol_sel == 2'b01 && upd_vld && !flush && upd_set == vq_set)
    |=> (vq_set != $past(vq_set) || !full || pol_sel != 2'b01 || vq_way != $past(upd_way))); // R4

  AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_sel == 2'b10 && upd_vld && upd_fill && !flush && upd_set == vq_set && full)
    |=> (vq_set != $past(vq_set) || !full || pol_sel != 2'b10 || vq_way == $past(rr_next))); // R5

  AST_FLUSH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && pol_sel != 2'b11) |=> (!full || $past(pol_sel) != pol_sel || vq_way == '0)); // R7

endmodule

bind repl_victim_sel repl_victim_chk #(.NUM_WAYS(NUM_WAYS), .SET_W(SET_W), .WAY_W(WAY_W)) u_chk (.*);

// File: tb/repl_victim_sel_bench.sv
`timescale 1ns/1ps
module repl_victim_sel_bench;
  localparam int NS = 8;
  localparam int NW = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic flush = 0;
  logic [1:0] pol_sel = 0;
  logic upd_vld = 0;
  logic [2:0] upd_set = 0;
  logic [1:0] upd_way = 0;
  logic upd_fill = 0;
  logic [2:0] vq_set = 0;
  logic [NW-1:0] vq_valid = '1;
  logic [1:0] vq_way;
  logic [0:0] one_way;

  always #2 clk = ~clk;

  repl_victim_sel #(.NUM_SETS(NS), .NUM_WAYS(NW)) u_repl_victim_sel (
    .clk, .rst_n, .flush, .pol_sel, .upd_vld, .upd_set, .upd_way, .upd_fill,
    .vq_set, .vq_valid, .vq_way);

  repl_victim_sel #(.NUM_SETS(NS), .NUM_WAYS(1)) u_one (
    .clk, .rst_n, .flush, .pol_sel, .upd_vld, .upd_set, .upd_way(1'b0), .upd_fill,
    .vq_set, .vq_valid(vq_valid[0]), .vq_way(one_way));

  int total = 0, bad = 0;
  int m_rank [NS][NW];
  int m_ptr  [NS];
  logic [15:0] m_lfsr;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) m_lfsr <= 16'hACE1;
    else        m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};

  task automatic m_init();
    for (int s = 0; s < NS; s++) begin
      m_ptr[s] = 0;
      for (int w = 0; w < NW; w++) m_rank[s][w] = w;
    end
  endtask

  task automatic m_update(int s, int w, bit fill);
    if (fill) m_ptr[s] = (m_ptr[s] + 1) % NW;
    if (fill || pol_sel == 2'b01) begin
      int r = m_rank[s][w];
      for (int k = 0; k < NW; k++)
        if (k == w) m_rank[s][k] = NW - 1;
        else if (m_rank[s][k] > r) m_rank[s][k]--;
    end
  endtask

  function automatic int exp_victim(int s, logic [NW-1:0] v);
    for (int w = 0; w < NW; w++) if (!v[w]) return w;
    case (pol_sel)
      2'b10: return m_ptr[s];
      2'b11: return int'(m_lfsr % NW);
      default: begin
        for (int w = 0; w < NW; w++) if (m_rank[s][w] == 0) return w;
        return -1;
      end
    endcase
  endfunction

  task automatic check(string req, int s, logic [NW-1:0] v);
    int e;
    @(negedge clk);
    vq_set = 3'(s); vq_valid = v;
    #0.5;
    e = exp_victim(s, v);
    total++;
    if (int'(vq_way) != e) begin
      bad++;
      $display("FAIL %s set=%0d valid=%b got=%0d exp=%0d", req, s, v, vq_way, e);
    end
    total++;
    if (one_way != 1'b0) begin
      bad++;
      $display("FAIL R1 single-way got=%0d exp=0", one_way);
    end
  endtask

  task automatic update(int s, int w, bit fill);
    @(negedge clk);
    upd_vld = 1; upd_set = 3'(s); upd_way = 2'(w); upd_fill = fill;
    @(posedge clk);
    #0.5;
    upd_vld = 0;
    m_update(s, w, fill);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1;
    @(posedge clk);
    #0.5;
    flush = 0;
    m_init();
  endtask

  task automatic random_phase(string req, int n);
    void'($urandom(32'h5eed + int'(pol_sel)));
    for (int i = 0; i < n; i++) begin
      int s = $urandom % NS;
      update(s, $urandom % NW, $urandom % 2);
      if ($urandom % 5 == 0) check("R2", $urandom % NS, NW'($urandom));
      else check(req, $urandom % NS, '1);
    end
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_init();
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;
    // R7: reset order, way 0 oldest in every set
    for (int s = 0; s < NS; s++) check("R7", s, '1);
    // R2: invalid-way shortcut
    check("R2", 1, 4'b1011);
    check("R2", 1, 4'b0000);
    check("R2", 2, 4'b0111);

    // R3: oldest-fill-first, hits ignored
    pol_sel = 2'b00; do_flush();
    update(0, 0, 1); update(0, 1, 1);
    update(0, 2, 0); update(0, 2, 0);
    check("R3", 0, '1);          // way 2 filled never, oldest remains 2
    update(0, 2, 1); update(0, 3, 1);
    check("R3", 0, '1);          // back to way 0
    check("R8", 1, '1);
    random_phase("R3", 600);

    // R4: LRU, hits promote
    pol_sel = 2'b01; do_flush();
    update(3, 0, 0); update(3, 1, 0); update(3, 2, 0);
    check("R4", 3, '1);          // way 3
    update(3, 3, 1);
    check("R4", 3, '1);          // way 0
    check("R8", 4, '1);
    random_phase("R4", 600);

    // R5: rotating pointer wraps
    pol_sel = 2'b10; do_flush();
    for (int i = 0; i < NW; i++) begin
      check("R5", 5, '1);
      update(5, 3, 1);
    end
    check("R5", 5, '1);          // wrapped to 0
    update(5, 1, 0);
    check("R5", 5, '1);          // hit does not advance
    check("R8", 6, '1);
    random_phase("R5", 600);

    // R7: flush wins over a concurrent update
    @(negedge clk);
    flush = 1; upd_vld = 1; upd_set = 5; upd_way = 0; upd_fill = 1;
    @(posedge clk);
    #0.5 flush = 0; upd_vld = 0; m_init();
    check("R7", 5, '1);

    // R6: random source
    pol_sel = 2'b11;
    for (int i = 0; i < 40; i++) check("R6", i % NS, '1);
    random_phase("R6", 400);

    // R9: update visible the very next cycle
    pol_sel = 2'b01; do_flush();
    update(7, 0, 1);
    check("R9", 7, '1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule